// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block is the output stage placed after a programmable sum-of-products array. It holds a bank of identical cells. Each cell takes one sum term from the array and produces three things: a pin drive value, a pin enable, and a feedback bit that returns to the array.

Two static configuration bits per cell pick the cell's behaviour. One bit chooses between registered and combinatorial operation. The other chooses the output polarity. The first bit also chooses where the feedback comes from: the cell's own flip-flop, or the pin.

All cells share one clock, one synchronous preset term and one asynchronous clear term. The clear overrides the preset. The pad is modelled as three signals:
- a drive value,
- an enable,
- an input that carries whatever an external source puts on the pin while the cell does not drive it.

Top module: `pld_out_bank`

## Requirements
- R1: Cell k reads its mode from `cfg_i[2k+1]` (0 = registered, 1 = combinatorial) and its polarity from `cfg_i[2k]` (1 = active-high, 0 = active-low, which inverts the pin value).
- R2: In registered mode the cell's flip-flop takes `sum_i[k]` on the rising clock edge. `pin_o[k]` shows the stored bit, inverted when active-low, right after that edge.
- R3: In combinatorial mode `pin_o[k]` follows `sum_i[k]` with no clock, inverted when active-low.
- R4: In registered mode `fb_o[k]` is the true flip-flop state, whatever the polarity setting.
- R5: In combinatorial mode `fb_o[k]` is the pin level. That level is `pin_o[k]` when the enable is high and `pin_i[k]` when the enable is low.
- R6: `pin_oe_o[k]` follows `oe_i[k]` in every mode. Releasing the pin does not change `pin_o[k]`.
- R7: While `preset_i` is high and `clear_i` is low, every flip-flop becomes 1 at the next rising edge and not before.
- R8: `clear_i` high forces every flip-flop to 0 at once, with no clock edge needed. The flip-flops stay 0 for as long as the clear is held.
- R9: When `clear_i` and `preset_i` are both high, the flip-flops are 0.
- R10: Each cell follows its own configuration. Cells with different modes run side by side in one bank.
- R11: `rst_ni` low clears every flip-flop asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock shared by all cells |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 2*N_CELLS | Static configuration, two bits per cell |
| sum_i | input | N_CELLS | Sum term from the array, one bit per cell |
| oe_i | input | N_CELLS | Per-cell output enable |
| preset_i | input | 1 | Global synchronous preset term |
| clear_i | input | 1 | Global asynchronous clear term |
| pin_i | input | N_CELLS | Level on each pin when it is not driven |
| pin_o | output | N_CELLS | Pin drive value |
| pin_oe_o | output | N_CELLS | Pin drive enable |
| fb_o | output | N_CELLS | Feedback to the array |

## Verification
Combinatorial pin and feedback results, and the enable, are due within the same cycle as the input change. The bench drives inputs on the falling edge and samples 1 ns later. Registered results and preset take effect one rising edge after the inputs, so the bench updates its own flip-flop model at that edge and samples 1 ns past it; it also checks just before the edge that the preset has not acted early. Clear and reset act with no edge at all. The bench checks them 1 ns after it raises them in the middle of a cycle, holds the clear across the following edge, and samples again after that edge.

// File: rtl/pld_mc_pkg.sv
`timescale 1ns/1ps
package pld_mc_pkg;
  localparam int CFG_W = 2;

  typedef enum logic [CFG_W-1:0] {
    MC_REG_LOW  = 2'b00,
    MC_REG_HIGH = 2'b01,
    MC_CMB_LOW  = 2'b10,
    MC_CMB_HIGH = 2'b11
  } mc_mode_e;

  function automatic logic is_comb(mc_mode_e m);
    return m[1];
  endfunction

  function automatic logic is_high(mc_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/pld_mc_ff.sv
`timescale 1ns/1ps
module pld_mc_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic preset_i,
  input  logic d_i,
  output logic q_o
);
  // clear is asynchronous and outranks the synchronous preset
  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (clear_i)  q_o <= 1'b0;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= d_i;
  end
endmodule

// File: rtl/pld_mc_cell.sv
`timescale 1ns/1ps
module pld_mc_cell
  import pld_mc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             sum_i,
  input  logic             oe_i,
  input  logic             preset_i,
  input  logic             clear_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             fb_o
);
  mc_mode_e mode;
  logic     q;
  logic     src;
  logic     pad_lvl;

  assign mode = mc_mode_e'(cfg_i);

  pld_mc_ff u_ff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .preset_i (preset_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  always_comb begin
    src      = is_comb(mode) ? sum_i : q;
    pin_o    = is_high(mode) ? src : ~src;
    pin_oe_o = oe_i;
    pad_lvl  = oe_i ? pin_o : pin_i;
    // registered feedback is the true flop state, polarity applies to the pin only
    fb_o     = is_comb(mode) ? pad_lvl : q;
  end
endmodule

// File: rtl/pld_out_bank.sv
`timescale 1ns/1ps
module pld_out_bank
  import pld_mc_pkg::*;
#(
  parameter int N_CELLS = 10,
  localparam int CFG_BITS = CFG_W * N_CELLS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CFG_BITS-1:0] cfg_i,
  input  logic [N_CELLS-1:0]  sum_i,
  input  logic [N_CELLS-1:0]  oe_i,
  input  logic                preset_i,
  input  logic                clear_i,
  input  logic [N_CELLS-1:0]  pin_i,
  output logic [N_CELLS-1:0]  pin_o,
  output logic [N_CELLS-1:0]  pin_oe_o,
  output logic [N_CELLS-1:0]  fb_o
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    pld_mc_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_i    (cfg_i[CFG_W*k +: CFG_W]),
      .sum_i    (sum_i[k]),
      .oe_i     (oe_i[k]),
      .preset_i (preset_i),
      .clear_i  (clear_i),
      .pin_i    (pin_i[k]),
      .pin_o    (pin_o[k]),
      .pin_oe_o (pin_oe_o[k]),
      .fb_o     (fb_o[k])
    );
  end
endmodule

// File: rtl/pld_mc_chk.sv
`timescale 1ns/1ps
module pld_mc_chk #(
  parameter int N_CELLS = 10,
  localparam int CFG_BITS = 2 * N_CELLS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CFG_BITS-1:0] cfg_i,
  input logic [N_CELLS-1:0]  sum_i,
  input logic [N_CELLS-1:0]  oe_i,
  input logic                preset_i,
  input logic                clear_i,
  input logic [N_CELLS-1:0]  pin_i,
  input logic [N_CELLS-1:0]  pin_o,
  input logic [N_CELLS-1:0]  pin_oe_o,
  input logic [N_CELLS-1:0]  fb_o
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_chk
    assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
      (!cfg_i[2*k+1] && !preset_i) |=> (cfg_i[2*k+1] || fb_o[k] == $past(sum_i[k])));

    assert_preset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
      (!cfg_i[2*k+1] && preset_i) |=> (cfg_i[2*k+1] || fb_o[k]));

    // covers R9 as well: preset has no say while clear is high
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[2*k+1] && clear_i) |-> !fb_o[k]);

    assert_reg_pol_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i[2*k+1] |-> (pin_o[k] == (fb_o[k] ^ ~cfg_i[2*k])));

    assert_cmb_pin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i[2*k+1] |-> (pin_o[k] == (sum_i[k] ^ ~cfg_i[2*k])));

    assert_cmb_fb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[2*k+1] && !oe_i[k]) |-> (fb_o[k] == pin_i[k]));

    assert_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[k] == oe_i[k]);
  end
endmodule

bind pld_out_bank pld_mc_chk #(.N_CELLS(N_CELLS)) u_chk (.*);

// File: tb/sim_pld_out_bank.sv
`timescale 1ns/1ps
module sim_pld_out_bank;
  localparam int N = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b1;
  logic [2*N-1:0] cfg_i = '0;
  logic [N-1:0]   sum_i = '0;
  logic [N-1:0]   oe_i = '0;
  logic           preset_i = 1'b0;
  logic           clear_i = 1'b0;
  logic [N-1:0]   pin_i = '0;
  logic [N-1:0]   pin_o, pin_oe_o, fb_o;

  logic [N-1:0]   mq;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  pld_out_bank #(.N_CELLS(N)) u0 (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R1: bit 2k+1 = combinatorial, bit 2k = active-high
  function automatic logic e_pin(int k);
    logic src;
    src = cfg_i[2*k+1] ? sum_i[k] : mq[k];
    return cfg_i[2*k] ? src : ~src;
  endfunction

  task automatic check_all(string ph);
    for (int k = 0; k < N; k++) begin
      logic ep, ef;
      ep = e_pin(k);
      ef = cfg_i[2*k+1] ? (oe_i[k] ? ep : pin_i[k]) : mq[k];
      chk(pin_o[k] === ep, $sformatf("%s/%s cell%0d pin", ph, cfg_i[2*k+1] ? "R3" : "R2", k),
          int'(pin_o[k]), int'(ep));
      chk(pin_oe_o[k] === oe_i[k], $sformatf("%s/R6 cell%0d oe", ph, k),
          int'(pin_oe_o[k]), int'(oe_i[k]));
      chk(fb_o[k] === ef, $sformatf("%s/%s cell%0d fb", ph, cfg_i[2*k+1] ? "R5" : "R4", k),
          int'(fb_o[k]), int'(ef));
    end
  endtask

  task automatic step(string ph, logic [N-1:0] s, logic [N-1:0] oe, logic [N-1:0] pi,
                      logic pre, logic clr);
    @(negedge clk_i);
    sum_i = s; oe_i = oe; pin_i = pi; preset_i = pre; clear_i = clr;
    if (clr) mq = '0;
    #1 check_all(ph);
    @(posedge clk_i);
    if (clr)      mq = '0;
    else if (pre) mq = '1;
    else          mq = sum_i;
    #1 check_all(ph);
  endtask

  task automatic set_cfg(int p);
    for (int k = 0; k < N; k++) cfg_i[2*k +: 2] = 2'((k + p) % 4);
  endtask

  initial begin
    #(10 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_cfg(0);
    mq = '0;
    #1 rst_ni = 1'b0;
    #1 check_all("R11 reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R10: mixed modes across the bank, each cell sees all four configurations
    for (int p = 0; p < 4; p++) begin
      @(negedge clk_i) set_cfg(p);
      for (int i = 0; i < 12; i++) begin
        logic [N-1:0] s, oe, pi;
        s  = N'((i * 413 + p * 97) ^ (i << 3));
        oe = N'((i * 181) ^ (p * 341));
        pi = ~s ^ N'(i * 5);
        step("R10 sweep", s, oe, pi, 1'b0, 1'b0);
      end
    end

    // R7 preset alone: unchanged before the edge, all ones after
    set_cfg(1);
    step("R7 setup", 10'h0a5, '1, '0, 1'b0, 1'b0);
    step("R7 preset", 10'h000, '1, '0, 1'b1, 1'b0);
    step("R7 release", 10'h15a, 10'h0f0, 10'h333, 1'b0, 1'b0);

    // R8 clear alone, raised mid-cycle and held across an edge
    step("R8 setup", '1, '1, '0, 1'b0, 1'b0);
    step("R8 clear", 10'h2aa, '1, '0, 1'b0, 1'b1);
    step("R8 release", 10'h155, 10'h1c3, 10'h0ff, 1'b0, 1'b0);

    // R9 clear and preset together
    set_cfg(2);
    step("R9 setup", '1, '1, '0, 1'b0, 1'b0);
    step("R9 both", 10'h3ff, '1, '0, 1'b1, 1'b1);
    step("R9 release", 10'h0c3, '0, 10'h2b4, 1'b0, 1'b0);

    // R11 reset in mid-operation
    set_cfg(3);
    step("R11 setup", '1, '1, '0, 1'b0, 1'b0);
    @(negedge clk_i) rst_ni = 1'b0;
    mq = '0;
    #1 check_all("R11 midreset");
    @(negedge clk_i) rst_ni = 1'b1;
    #1 check_all("R11 after");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule